// File: doc/BRIEF.md
# Two-Symbol Stream Grammar Checker

This block watches a stream of symbols drawn from a two-letter alphabet, called a and b, and delivered one symbol per cycle. A symbol is read only on a cycle where the valid strobe is high. Two rules apply. An a may never be followed directly by another a, so every a must be followed by at least one b. A run of b symbols may be at most `MAX_RUN` long (default five). Once a run reaches that length, the next symbol must be an a.

The checker does not give each position in a b-run its own state. It pairs a four-state control machine with a saturating run counter that is incremented, compared against the limit and cleared. The `accept` output says that the stream consumed so far is legal. The `err` output goes high on the first violation and stays high until reset. The empty stream right after reset is legal.

Top module: `sgc_checker`

## Requirements
- R1: Right after reset, `err` is 0 and `accept` is 1.
- R2: A cycle with `sym_vld` low consumes nothing. The outputs and the internal run length stay unchanged, whatever `sym_is_b` holds.
- R3: The symbol encoding is `sym_is_b`=1 for b and `sym_is_b`=0 for a. A valid a whose previous valid symbol was an a sets `err` on the clock edge that consumes it.
- R4: A valid b that would make the current run of consecutive b symbols longer than `MAX_RUN` sets `err` on the clock edge that consumes it.
- R5: A valid a clears the run length. A run of exactly `MAX_RUN` b symbols followed by an a is legal, and a fresh run of `MAX_RUN` b symbols may then follow.
- R6: Once set, `err` stays 1 for any input until reset.
- R7: `accept` is the inverse of `err` at every cycle.
- R8: A stream may legally start with either symbol. A single a is accepted, and so is a first run of up to `MAX_RUN` b symbols.
- R9: Asserting reset while `err` is set returns the checker to its start state. The grammar rules then apply afresh from an empty stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld | input | 1 | A symbol is present this cycle |
| sym_is_b | input | 1 | Symbol value: 1 = b, 0 = a |
| accept | output | 1 | Stream consumed so far is legal |
| err | output | 1 | Sticky grammar violation flag |

## Verification
The bench goes after the run limit from both sides. A run of exactly `MAX_RUN` b symbols must pass, and one more b must fail; an off-by-one compare would either reject the legal run or let the illegal one through. It places idle cycles carrying an a value between two legal symbols, where a design that ignores the strobe would see a double a and raise a false error. It also checks that an a restarts the count, which a design that only saturates would miss by failing a later legal run. Finally, it checks that the error flag survives legal traffic and clears only on reset, which a design that recomputes the flag from the latest symbols would get wrong.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  typedef enum logic [1:0] {
    S_START  = 2'd0,
    S_NEED_B = 2'd1,
    S_IN_RUN = 2'd2,
    S_ERR    = 2'd3
  } sgc_state_e;

  function automatic int unsigned run_width(input int unsigned max_run);
    return (max_run < 1) ? 1 : $clog2(max_run + 1);
  endfunction

  // a run at its cap forbids one more b
  function automatic logic run_full(input int unsigned count, input int unsigned max_run);
    return count >= max_run;
  endfunction

endpackage

// File: rtl/sgc_run_counter.sv
module sgc_run_counter #(
  parameter int unsigned MAX_RUN = 5,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  import sgc_pkg::*;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  assign count    = count_q;
  assign at_limit = run_full(int'(count_q), MAX_RUN);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= MAX_RUN);

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));

endmodule

// File: rtl/sgc_ctrl.sv
module sgc_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_vld,
  input  logic                sym_is_b,
  input  logic                at_limit,
  output sgc_pkg::sgc_state_e state,
  output logic                cnt_clr,
  output logic                cnt_inc,
  output logic                viol_aa,
  output logic                viol_run
);
  import sgc_pkg::*;

  sgc_state_e state_q, state_d;
  logic       live;

  assign live     = sym_vld && (state_q != S_ERR);
  assign viol_aa  = live && !sym_is_b && (state_q == S_NEED_B);
  assign viol_run = live && sym_is_b && at_limit;
  assign cnt_clr  = live && !sym_is_b && !viol_aa;
  assign cnt_inc  = live && sym_is_b && !viol_run;

  always_comb begin
    state_d = state_q;
    if (viol_aa || viol_run) state_d = S_ERR;
    else if (cnt_clr)        state_d = S_NEED_B;
    else if (cnt_inc)        state_d = S_IN_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_START;
    else        state_q <= state_d;
  end

  assign state = state_q;

  a_r3_double_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && !sym_is_b && state_q == S_NEED_B) |=> (state_q == S_ERR));

  a_r6_err_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ERR) |=> (state_q == S_ERR));

endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
  parameter int unsigned MAX_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_vld,
  input  logic sym_is_b,
  output logic accept,
  output logic err
);
  import sgc_pkg::*;

  localparam int unsigned CNT_W = run_width(MAX_RUN);

  sgc_state_e       state;
  logic             cnt_clr, cnt_inc, at_limit;
  logic             viol_aa, viol_run;
  logic [CNT_W-1:0] run_len;

  sgc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_vld  (sym_vld),
    .sym_is_b (sym_is_b),
    .at_limit (at_limit),
    .state    (state),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .viol_aa  (viol_aa),
    .viol_run (viol_run)
  );

  sgc_run_counter #(.MAX_RUN(MAX_RUN), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .count    (run_len),
    .at_limit (at_limit)
  );

  assign err    = (state == S_ERR);
  assign accept = !err;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> ($stable(state) && $stable(run_len)));

  a_r4_long_run: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && sym_is_b && int'(run_len) == MAX_RUN) |=> err);

  a_r3_viol_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({viol_aa, viol_run, cnt_clr, cnt_inc}));

endmodule

// File: tb/sgc_checker_tb.sv
module sgc_checker_tb;
  localparam int MAX_RUN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0;
  logic sym_is_b = 1'b0;
  logic accept, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit m_err;
  bit m_prev_a;
  int m_run;

  always #4 clk = ~clk;

  sgc_checker #(.MAX_RUN(MAX_RUN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_is_b(sym_is_b),
    .accept(accept), .err(err)
  );

  function automatic bit ref_violates(bit prev_a, int run, bit is_b);
    return is_b ? (run >= MAX_RUN) : prev_a;
  endfunction

  task automatic model_reset();
    m_err = 0; m_prev_a = 0; m_run = 0;
  endtask

  task automatic model_step(bit vld, bit is_b);
    if (!vld || m_err) return;
    if (ref_violates(m_prev_a, m_run, is_b)) m_err = 1;
    else if (is_b) begin m_run++; m_prev_a = 0; end
    else begin m_run = 0; m_prev_a = 1; end
  endtask

  task automatic check(string tag);
    checks++;
    if (err !== m_err || accept !== !m_err) begin
      errors++;
      $display("FAIL %s: got err=%0d accept=%0d expected err=%0d accept=%0d",
               tag, err, accept, m_err, !m_err);
    end
  endtask

  // called at a negedge: drive, let one rising edge pass, check at next negedge
  task automatic step(bit vld, bit is_b, string tag);
    sym_vld = vld; sym_is_b = is_b;
    model_step(vld, is_b);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0; sym_vld = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    @(negedge clk);
    do_reset("R1 reset state");

    // R8 start with a, R3 double a
    step(1, 0, "R8 leading a accepted");
    step(1, 0, "R3 a after a flags error");
    // R6 sticky under legal traffic
    for (int i = 0; i < 4; i++) step(1, 1, "R6 error sticky");
    step(1, 0, "R6 error sticky after a");
    step(0, 1, "R7 accept low while err");

    // R9 reset from error
    do_reset("R9 reset clears error");
    // R8 leading b run of MAX_RUN, R5 then a, then fresh run
    for (int i = 0; i < MAX_RUN; i++) step(1, 1, "R8 leading b run");
    step(1, 0, "R5 a after full run legal");
    for (int i = 0; i < MAX_RUN; i++) step(1, 1, "R5 fresh run after a");
    step(1, 1, "R4 run exceeds limit");

    // R2 idle cycles with a on the bus between a and b
    do_reset("R1 reset again");
    step(1, 0, "R2 first a");
    for (int i = 0; i < 3; i++) step(0, 0, "R2 idle a ignored");
    step(1, 1, "R2 b after idle");
    step(1, 1, "R2 second b");
    for (int i = 0; i < 2; i++) step(0, 1, "R2 idle b ignored");
    step(1, 1, "R2 third b");
    step(1, 1, "R2 fourth b");
    step(1, 1, "R2 fifth b legal");
    step(1, 1, "R4 sixth b after idles");

    // R5 partial run then a resets the count
    do_reset("R1 reset before partial run");
    for (int i = 0; i < MAX_RUN - 1; i++) step(1, 1, "R5 partial run");
    step(1, 0, "R5 a clears run");
    for (int i = 0; i < MAX_RUN; i++) step(1, 1, "R5 full run after clear");
    step(1, 0, "R5 a closes run");

    // random traffic, b-weighted to reach long runs
    do_reset("R1 reset before random");
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 300) == 0) do_reset("R9 random reset");
      else step(($urandom % 4) != 0, ($urandom % 8) < 6, "R7 random stream");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule